// File: doc/BRIEF.md
# Bus activity and idle detector

This block sits behind the comparators of a two-wire differential bus receiver and decides whether the bus carries traffic. Three comparator flags come in, already sampled to the system clock: one says the absolute differential level is above the activity threshold, one says the level is clearly high, and one says it is clearly low. A qualification timer declares activity only after the level has stayed above the activity threshold for a programmable number of cycles. A second timer declares idle only after the level has stayed below that threshold for its own programmable number of cycles. An active-low receive-enable output reports the result. A receive-data output follows the bus while it is active and is forced high while it is idle.

When the star option is enabled, two further filtered detectors run on the same kind of timer. One watches an active-low local transmit-enable pin. The other watches the wired-AND of two branch data pins, which idle high. Each reports its own activity flag. With the option disabled, both flags are tied low.

Every filter counter restarts whenever its qualifying condition breaks. A glitch shorter than the limit therefore never changes a state. All limits are parameters of at least one cycle.

Top module: `bus_act_idle_det`

## Requirements
- R1: After reset, rx_en_n is 1, rx_data is 1, and both star activity flags are 0.
- R2: Activity is declared, and rx_en_n goes to 0, after the clock edge at which lvl_act has been sampled 1 on ACT_LIM consecutive edges. One edge fewer leaves rx_en_n at 1.
- R3: While activity is declared, rx_en_n is 0. On the edge that declares activity, rx_data is still 1.
- R4: While active, from the edge after activity is declared onward, rx_data takes the level sampled at the previous edge: 1 when lvl_hi is 1 (lvl_hi wins if both flags are set), and 0 when only lvl_lo is 1.
- R5: While active, an edge with both lvl_hi and lvl_lo at 0 leaves rx_data unchanged.
- R6: Idle is declared after the edge at which lvl_act has been sampled 0 on IDLE_LIM consecutive edges. rx_en_n then returns to 1 and rx_data to 1.
- R7: Any break in a qualifying condition before its limit restarts the count from zero, so a run shorter than the limit changes no state.
- R8: While idle, rx_data stays 1 whatever lvl_hi and lvl_lo show.
- R9: With STAR_EN set, star_tx_act rises after tx_en_n has been sampled 0 on TX_ACT_LIM consecutive edges, and falls after it has been sampled 1 on TX_IDLE_LIM consecutive edges.
- R10: With STAR_EN set, star_br_act rises after either branch pin has been sampled 0 on BR_ACT_LIM consecutive edges. It falls only after both pins have been sampled 1 on BR_IDLE_LIM consecutive edges; one pin held low keeps it active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all filters count its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_act | input | 1 | Absolute differential level above the activity threshold |
| lvl_hi | input | 1 | Differential level above the high threshold |
| lvl_lo | input | 1 | Differential level below the low threshold |
| tx_en_n | input | 1 | Local transmit enable, active low (star mode) |
| br0 | input | 1 | Branch 0 data pin, idles high (star mode) |
| br1 | input | 1 | Branch 1 data pin, idles high (star mode) |
| rx_en_n | output | 1 | 0 while bus activity is declared |
| rx_data | output | 1 | Received data; held at 1 while idle |
| star_tx_act | output | 1 | Filtered activity on the transmit-enable pin |
| star_br_act | output | 1 | Filtered activity on the branch pins |

## Verification
The assertions assume that every input is already synchronous to clk. The data-path properties also assume that lvl_hi and lvl_lo have meaning only while the level is above the activity threshold. The bench changes all inputs at the falling edge, so each rising edge samples stable values. It asserts lvl_hi or lvl_lo together with lvl_act, apart from one deliberate case that shows the data flags are ignored while idle. Runs are sized one edge short of each limit and exactly at it, so the timers are checked at their boundaries.

// File: rtl/bus_det_pkg.sv
package bus_det_pkg;
   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int cnt_bits(input int lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction
endpackage

// File: rtl/qual_filter.sv
module qual_filter
   import bus_det_pkg::*;
#(
   parameter int ACT_LIM  = 4,
   parameter int IDLE_LIM = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic active
);
   localparam int LIM_MAX = max2(ACT_LIM, IDLE_LIM);
   localparam int CNT_W   = cnt_bits(LIM_MAX);
   localparam logic [CNT_W-1:0] ACT_END  = CNT_W'(ACT_LIM - 1);
   localparam logic [CNT_W-1:0] IDLE_END = CNT_W'(IDLE_LIM - 1);

   if (ACT_LIM < 1)  begin : g_bad_act  $error("ACT_LIM must be at least 1");  end
   if (IDLE_LIM < 1) begin : g_bad_idle $error("IDLE_LIM must be at least 1"); end

   logic [CNT_W-1:0] cnt;
   logic             run;

   // the condition that moves the state away from where it is
   assign run = active ? ~cond : cond;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == (active ? IDLE_END : ACT_END)) begin
         cnt    <= '0;
         active <= ~active;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_rise_after_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(cond));
   assert_fall_after_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> !$past(cond));
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(LIM_MAX));
endmodule

// File: rtl/rx_data_path.sv
module rx_data_path (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic lvl_hi,
   input  logic lvl_lo,
   output logic rx_data
);
   logic held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held <= 1'b1;
      else if (!active) held <= 1'b1;
      else if (lvl_hi) held <= 1'b1;
      else if (lvl_lo) held <= 1'b0;
   end

   assign rx_data = active ? held : 1'b1;

   assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> rx_data);
   assert_follow_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && $past(lvl_hi)) |-> rx_data);
   assert_follow_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && $past(lvl_lo && !lvl_hi)) |-> !rx_data);
   assert_hold_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && $past(!lvl_hi && !lvl_lo)) |-> rx_data == $past(rx_data));
endmodule

// File: rtl/bus_act_idle_det.sv
module bus_act_idle_det #(
   parameter int ACT_LIM     = 4,
   parameter int IDLE_LIM    = 8,
   parameter bit STAR_EN     = 1'b1,
   parameter int TX_ACT_LIM  = 3,
   parameter int TX_IDLE_LIM = 6,
   parameter int BR_ACT_LIM  = 2,
   parameter int BR_IDLE_LIM = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_act,
   input  logic lvl_hi,
   input  logic lvl_lo,
   input  logic tx_en_n,
   input  logic br0,
   input  logic br1,
   output logic rx_en_n,
   output logic rx_data,
   output logic star_tx_act,
   output logic star_br_act
);
   logic bus_active;

   qual_filter #(.ACT_LIM(ACT_LIM), .IDLE_LIM(IDLE_LIM)) u_bus_flt (
      .clk(clk), .rst_n(rst_n), .cond(lvl_act), .active(bus_active));

   rx_data_path u_rxd (
      .clk(clk), .rst_n(rst_n), .active(bus_active),
      .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .rx_data(rx_data));

   assign rx_en_n = ~bus_active;

   if (STAR_EN) begin : g_star
      logic br_any_low;
      assign br_any_low = ~(br0 & br1);

      qual_filter #(.ACT_LIM(TX_ACT_LIM), .IDLE_LIM(TX_IDLE_LIM)) u_tx_flt (
         .clk(clk), .rst_n(rst_n), .cond(~tx_en_n), .active(star_tx_act));
      qual_filter #(.ACT_LIM(BR_ACT_LIM), .IDLE_LIM(BR_IDLE_LIM)) u_br_flt (
         .clk(clk), .rst_n(rst_n), .cond(br_any_low), .active(star_br_act));

      assert_br_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(star_br_act) && $past(br_any_low)) |-> star_br_act);
   end else begin : g_node
      assign star_tx_act = 1'b0;
      assign star_br_act = 1'b0;
   end

   assert_en_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en_n |-> rx_data);
endmodule

// File: tb/sim_bus_act_idle_det.sv
module sim_bus_act_idle_det;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lvl_act = 0, lvl_hi = 0, lvl_lo = 0;
   logic tx_en_n = 1, br0 = 1, br1 = 1;
   logic rx_en_n, rx_data, star_tx_act, star_br_act;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   bus_act_idle_det #(.ACT_LIM(4), .IDLE_LIM(8), .STAR_EN(1'b1),
      .TX_ACT_LIM(3), .TX_IDLE_LIM(6), .BR_ACT_LIM(2), .BR_IDLE_LIM(5)) u0 (
      .clk(clk), .rst_n(rst_n), .lvl_act(lvl_act), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
      .tx_en_n(tx_en_n), .br0(br0), .br1(br1), .rx_en_n(rx_en_n), .rx_data(rx_data),
      .star_tx_act(star_tx_act), .star_br_act(star_br_act));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 rx_en_n", rx_en_n, 1'b1);
      chk("R1 rx_data", rx_data, 1'b1);
      chk("R1 star_tx_act", star_tx_act, 1'b0);
      chk("R1 star_br_act", star_br_act, 1'b0);
   endtask

   task automatic t_glitch_and_idle_data;
      lvl_act = 1; lvl_lo = 1; cyc(3);
      chk("R2 short run", rx_en_n, 1'b1);
      chk("R8 lo ignored idle", rx_data, 1'b1);
      lvl_act = 0; lvl_lo = 0; cyc(1);
      lvl_act = 1; cyc(3);
      chk("R7 restart act", rx_en_n, 1'b1);
      lvl_act = 0; cyc(2);
      // deliberate: data flag set while idle
      lvl_lo = 1; cyc(2);
      chk("R8 lo without act", rx_data, 1'b1);
      lvl_lo = 0;
   endtask

   task automatic t_activity_data;
      lvl_act = 1; lvl_lo = 1; cyc(4);
      chk("R2 detect", rx_en_n, 1'b0);
      chk("R3 data at detect", rx_data, 1'b1);
      cyc(1);
      chk("R4 follow lo", rx_data, 1'b0);
      lvl_hi = 1; cyc(1);
      chk("R4 hi wins", rx_data, 1'b1);
      lvl_lo = 0; cyc(1);
      lvl_hi = 0; lvl_lo = 1; cyc(1);
      chk("R4 lo again", rx_data, 1'b0);
      lvl_lo = 0; cyc(3);
      chk("R5 hold low", rx_data, 1'b0);
      lvl_hi = 1; cyc(1);
      lvl_hi = 0; cyc(2);
      chk("R5 hold high", rx_data, 1'b1);
      lvl_lo = 1; cyc(1);
      lvl_lo = 0;
      chk("R3 still active", rx_en_n, 1'b0);
   endtask

   task automatic t_idle;
      lvl_act = 0; cyc(7);
      chk("R6 short quiet", rx_en_n, 1'b0);
      chk("R5 hold through quiet", rx_data, 1'b0);
      lvl_act = 1; cyc(1);
      lvl_act = 0; cyc(7);
      chk("R7 restart idle", rx_en_n, 1'b0);
      cyc(1);
      chk("R6 idle en", rx_en_n, 1'b1);
      chk("R6 idle data", rx_data, 1'b1);
   endtask

   task automatic t_star_tx;
      tx_en_n = 0; cyc(2);
      chk("R9 short low", star_tx_act, 1'b0);
      cyc(1);
      chk("R9 tx active", star_tx_act, 1'b1);
      tx_en_n = 1; cyc(5);
      chk("R9 short high", star_tx_act, 1'b1);
      cyc(1);
      chk("R9 tx idle", star_tx_act, 1'b0);
   endtask

   task automatic t_star_br;
      br0 = 0; cyc(1);
      chk("R10 short low", star_br_act, 1'b0);
      cyc(1);
      chk("R10 br0 active", star_br_act, 1'b1);
      br0 = 1; br1 = 0; cyc(10);
      chk("R10 one pin low", star_br_act, 1'b1);
      br1 = 1; cyc(4);
      chk("R10 short high", star_br_act, 1'b1);
      cyc(1);
      chk("R10 br idle", star_br_act, 1'b0);
      br1 = 0; cyc(2);
      chk("R10 br1 active", star_br_act, 1'b1);
      br1 = 1; cyc(5);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      t_reset();
      t_glitch_and_idle_data();
      t_activity_data();
      t_idle();
      t_star_tx();
      t_star_br();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule